// File: doc/BRIEF.md
# Write-Once Snooping Cache Line Controller

This block keeps the coherence state of every line of a direct-mapped primary data cache that sits on a shared snooping bus. It uses a four-state write-once scheme. A line is absent, clean and shared, exclusive but still equal to memory, or exclusive and modified. The first processor store to a line is also sent to memory, so that other caches drop their copies. Later stores stay local until the line is evicted or taken away by another master.

The processor side is a valid/ready handshake for full-line loads and stores. The bus master side carries one request at a time: a read, a read for ownership, or a write. The slave side answers snooped reads and reads for ownership from other caches, and it also answers the transactional forms of those cycles. It does not look at the transactional flag. Tag, state and data storage are plain registers inside the block.

Top module: `wo_line_ctrl`

## Requirements
- R1: After reset every line is absent. `cpu_ready`, `bus_req` and `snp_supply` are low, and a snoop to any address supplies nothing.
- R2: A load that misses issues one read cycle (`bus_cmd` 0) at the load address. In the cycle `bus_done` is high it completes with `cpu_rdata` equal to `bus_rdata`, and the line becomes clean-shared. A following load to that address completes with no bus cycle and returns the same data.
- R3: A store that misses issues a read for ownership (`bus_cmd` 1) at the store address, then a write cycle (`bus_cmd` 2) carrying the store data to the same address. It completes with the write, and the line becomes exclusive-unmodified.
- R4: A store to a clean-shared line issues only a write cycle carrying the store data, and the line becomes exclusive-unmodified.
- R5: A store to an exclusive line, modified or not, completes in the cycle it is presented with no bus cycle, and the line becomes exclusive-modified.
- R6: A miss that evicts a modified line first issues a write cycle carrying the victim's address and data. A miss that evicts an unmodified line issues no write for it.
- R7: A snooped read (`snp_cmd` 0) or transactional read (`snp_cmd` 2) that hits a clean-shared line supplies the line data, and the line stays clean-shared.
- R8: A snooped read or transactional read that hits an exclusive line supplies the data and moves the line to clean-shared. A later store then writes through again, and a later eviction writes nothing back.
- R9: A snooped read for ownership (`snp_cmd` 1) or transactional read for ownership (`snp_cmd` 3) that hits a line supplies the data and makes the line absent.
- R10: A snoop whose address is not held supplies nothing and leaves every line as it was.
- R11: At most one bus request is outstanding. While `bus_done` is low, `bus_req`, `bus_cmd` and `bus_addr` hold steady. `cpu_ready` is raised only in the cycle the processor request completes.
- R12: When a snoop targets the same line index as a processor request arriving while idle, the snoop takes effect and the processor request is held off that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_valid | input | 1 | Processor request present |
| cpu_write | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Line address of the request |
| cpu_wdata | input | DATA_W | Store data (whole line) |
| cpu_ready | output | 1 | Request completes this cycle |
| cpu_rdata | output | DATA_W | Load data, valid with cpu_ready |
| bus_req | output | 1 | Bus request outstanding |
| bus_cmd | output | 2 | 0 read, 1 read for ownership, 2 write |
| bus_addr | output | ADDR_W | Address of the bus request |
| bus_wdata | output | DATA_W | Data of a write cycle |
| bus_done | input | 1 | Outstanding request completes this cycle |
| bus_rdata | input | DATA_W | Fill data, valid with bus_done |
| snp_valid | input | 1 | Snooped cycle from another master |
| snp_cmd | input | 2 | Bit 0 ownership, bit 1 transactional flag |
| snp_addr | input | ADDR_W | Snooped line address |
| snp_supply | output | 1 | This cache supplies the line |
| snp_rdata | output | DATA_W | Supplied data, valid with snp_supply |

## Verification
The assertions assume that a processor request is held stable until `cpu_ready`, and that `bus_done` is raised only while `bus_req` is high. They also assume that no snoop arrives while this cache owns the bus, since the bus serves one master at a time. The stimulus follows these rules. Every processor operation runs to its handshake before the next one starts, and the bench answers bus requests only while they are raised. Snoops are issued only between processor operations, with one deliberate exception: a snoop presented together with a new request while the controller is idle.

// File: rtl/wo_pkg.sv
package wo_pkg;
    typedef enum logic [1:0] {
        LN_INVALID  = 2'd0,
        LN_VALID    = 2'd1,
        LN_RESERVED = 2'd2,
        LN_DIRTY    = 2'd3
    } line_st_e;

    typedef enum logic [1:0] {
        BUS_READ  = 2'd0,
        BUS_RFO   = 2'd1,
        BUS_WRITE = 2'd2
    } bus_cmd_e;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_WBACK = 2'd1,
        PH_FILL  = 2'd2,
        PH_WTHRU = 2'd3
    } phase_e;

    // snoop command: bit 0 requests ownership, bit 1 marks a transactional cycle
    localparam int SNP_OWN_BIT = 0;
endpackage

// File: rtl/wo_line_array.sv
module wo_line_array
    import wo_pkg::*;
#(
    parameter int LINES  = 2048,
    parameter int TAG_W  = 5,
    parameter int DATA_W = 64,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  a_idx,
    output line_st_e          a_state,
    output logic [TAG_W-1:0]  a_tag,
    output logic [DATA_W-1:0] a_data,
    input  logic [IDX_W-1:0]  b_idx,
    output line_st_e          b_state,
    output logic [TAG_W-1:0]  b_tag,
    output logic [DATA_W-1:0] b_data,
    input  logic              snp_we,
    input  logic [IDX_W-1:0]  snp_idx,
    input  line_st_e          snp_state,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  line_st_e          wr_state,
    input  logic [DATA_W-1:0] wr_data
);
    line_st_e          st_q   [LINES];
    logic [TAG_W-1:0]  tag_q  [LINES];
    logic [DATA_W-1:0] data_q [LINES];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < LINES; i++) st_q[i] <= LN_INVALID;
        end else begin
            if (snp_we) st_q[snp_idx] <= snp_state;
            if (wr_en)  st_q[wr_idx]  <= wr_state;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx]  <= wr_tag;
            data_q[wr_idx] <= wr_data;
        end
    end

    assign a_state = st_q[a_idx];
    assign a_tag   = tag_q[a_idx];
    assign a_data  = data_q[a_idx];
    assign b_state = st_q[b_idx];
    assign b_tag   = tag_q[b_idx];
    assign b_data  = data_q[b_idx];
endmodule

// File: rtl/wo_snoop_resp.sv
module wo_snoop_resp
    import wo_pkg::*;
#(
    parameter int TAG_W  = 5,
    parameter int DATA_W = 64
) (
    input  logic              snp_valid,
    input  logic [1:0]        snp_cmd,
    input  logic [TAG_W-1:0]  snp_tag,
    input  line_st_e          line_state,
    input  logic [TAG_W-1:0]  line_tag,
    input  logic [DATA_W-1:0] line_data,
    output logic              supply,
    output logic [DATA_W-1:0] rdata,
    output logic              st_we,
    output line_st_e          st_next
);
    logic hit;
    logic unused_txn_flag;

    // the transactional flag selects nothing: both forms behave alike
    assign unused_txn_flag = snp_cmd[1];
    assign hit     = snp_valid && (line_state != LN_INVALID) && (line_tag == snp_tag);
    assign supply  = hit;
    assign rdata   = hit ? line_data : '0;
    assign st_we   = hit;
    assign st_next = snp_cmd[SNP_OWN_BIT] ? LN_INVALID : LN_VALID;
endmodule

// File: rtl/wo_line_ctrl.sv
module wo_line_ctrl
    import wo_pkg::*;
#(
    parameter int LINES  = 2048,
    parameter int ADDR_W = 16,
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_valid,
    input  logic              cpu_write,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_ready,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              bus_req,
    output logic [1:0]        bus_cmd,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_done,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              snp_valid,
    input  logic [1:0]        snp_cmd,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              snp_supply,
    output logic [DATA_W-1:0] snp_rdata
);
    localparam int IDX_W = $clog2(LINES);
    localparam int TAG_W = ADDR_W - IDX_W;

    typedef struct packed {
        phase_e            ph;
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } ctrl_t;

    ctrl_t ctl_d, ctl_q;

    logic [IDX_W-1:0]  a_idx;
    line_st_e          a_state;
    logic [TAG_W-1:0]  a_tag;
    logic [DATA_W-1:0] a_data;
    line_st_e          b_state;
    logic [TAG_W-1:0]  b_tag;
    logic [DATA_W-1:0] b_data;
    logic              snp_we;
    line_st_e          snp_state;
    logic              wr_en;
    logic [IDX_W-1:0]  wr_idx;
    logic [TAG_W-1:0]  wr_tag;
    line_st_e          wr_state;
    logic [DATA_W-1:0] wr_data;

    logic [IDX_W-1:0] cpu_idx;
    logic [TAG_W-1:0] cpu_tag;
    logic [IDX_W-1:0] q_idx;
    logic [TAG_W-1:0] q_tag;
    logic             cpu_hit;
    logic             idx_clash;

    assign cpu_idx   = cpu_addr[IDX_W-1:0];
    assign cpu_tag   = cpu_addr[ADDR_W-1:IDX_W];
    assign q_idx     = ctl_q.addr[IDX_W-1:0];
    assign q_tag     = ctl_q.addr[ADDR_W-1:IDX_W];
    assign a_idx     = (ctl_q.ph == PH_IDLE) ? cpu_idx : q_idx;
    assign cpu_hit   = (a_state != LN_INVALID) && (a_tag == cpu_tag);
    assign idx_clash = snp_valid && (snp_addr[IDX_W-1:0] == cpu_idx);

    wo_line_array #(.LINES(LINES), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .a_idx     (a_idx),
        .a_state   (a_state),
        .a_tag     (a_tag),
        .a_data    (a_data),
        .b_idx     (snp_addr[IDX_W-1:0]),
        .b_state   (b_state),
        .b_tag     (b_tag),
        .b_data    (b_data),
        .snp_we    (snp_we),
        .snp_idx   (snp_addr[IDX_W-1:0]),
        .snp_state (snp_state),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_tag    (wr_tag),
        .wr_state  (wr_state),
        .wr_data   (wr_data)
    );

    wo_snoop_resp #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_snoop (
        .snp_valid  (snp_valid),
        .snp_cmd    (snp_cmd),
        .snp_tag    (snp_addr[ADDR_W-1:IDX_W]),
        .line_state (b_state),
        .line_tag   (b_tag),
        .line_data  (b_data),
        .supply     (snp_supply),
        .rdata      (snp_rdata),
        .st_we      (snp_we),
        .st_next    (snp_state)
    );

    always_comb begin
        ctl_d     = ctl_q;
        cpu_ready = 1'b0;
        cpu_rdata = '0;
        bus_req   = 1'b0;
        bus_cmd   = BUS_READ;
        bus_addr  = '0;
        bus_wdata = '0;
        wr_en     = 1'b0;
        wr_idx    = q_idx;
        wr_tag    = q_tag;
        wr_state  = LN_INVALID;
        wr_data   = ctl_q.wdata;
        unique case (ctl_q.ph)
            PH_IDLE: begin
                if (cpu_valid && !idx_clash) begin
                    if (!cpu_write && cpu_hit) begin
                        cpu_ready = 1'b1;
                        cpu_rdata = a_data;
                    end else if (cpu_write && cpu_hit &&
                                 (a_state == LN_RESERVED || a_state == LN_DIRTY)) begin
                        cpu_ready = 1'b1;
                        wr_en     = 1'b1;
                        wr_idx    = cpu_idx;
                        wr_tag    = cpu_tag;
                        wr_state  = LN_DIRTY;
                        wr_data   = cpu_wdata;
                    end else begin
                        ctl_d.wr    = cpu_write;
                        ctl_d.addr  = cpu_addr;
                        ctl_d.wdata = cpu_wdata;
                        if (cpu_hit)                  ctl_d.ph = PH_WTHRU;
                        else if (a_state == LN_DIRTY) ctl_d.ph = PH_WBACK;
                        else                          ctl_d.ph = PH_FILL;
                    end
                end
            end
            PH_WBACK: begin
                bus_req   = 1'b1;
                bus_cmd   = BUS_WRITE;
                bus_addr  = {a_tag, q_idx};
                bus_wdata = a_data;
                if (bus_done) ctl_d.ph = PH_FILL;
            end
            PH_FILL: begin
                bus_req  = 1'b1;
                bus_cmd  = ctl_q.wr ? BUS_RFO : BUS_READ;
                bus_addr = ctl_q.addr;
                if (bus_done) begin
                    if (ctl_q.wr) begin
                        ctl_d.ph = PH_WTHRU;
                    end else begin
                        wr_en     = 1'b1;
                        wr_state  = LN_VALID;
                        wr_data   = bus_rdata;
                        cpu_ready = 1'b1;
                        cpu_rdata = bus_rdata;
                        ctl_d.ph  = PH_IDLE;
                    end
                end
            end
            PH_WTHRU: begin
                bus_req   = 1'b1;
                bus_cmd   = BUS_WRITE;
                bus_addr  = ctl_q.addr;
                bus_wdata = ctl_q.wdata;
                if (bus_done) begin
                    wr_en     = 1'b1;
                    wr_state  = LN_RESERVED;
                    cpu_ready = 1'b1;
                    ctl_d.ph  = PH_IDLE;
                end
            end
            default: ctl_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '{ph: PH_IDLE, wr: 1'b0, addr: '0, wdata: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end
endmodule

// File: rtl/wo_line_chk.sv
module wo_line_chk #(
    parameter int LINES  = 2048,
    parameter int ADDR_W = 16,
    parameter int DATA_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_valid,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic              cpu_ready,
    input logic [DATA_W-1:0] cpu_rdata,
    input logic              bus_req,
    input logic [1:0]        bus_cmd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_done,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              snp_valid,
    input logic [ADDR_W-1:0] snp_addr,
    input logic              snp_supply
);
    localparam int IDX_W = $clog2(LINES);

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_done) |=> (bus_req && $stable(bus_cmd) && $stable(bus_addr))); // R11
    AST_READY_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |-> cpu_valid); // R11
    AST_READ_RETURNS_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_cmd == 2'd0 && bus_done) |-> (cpu_ready && cpu_rdata == bus_rdata)); // R2
    AST_RFO_THEN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_cmd == 2'd1 && bus_done) |=>
        (bus_req && bus_cmd == 2'd2 && bus_addr == $past(bus_addr))); // R3
    AST_SUPPLY_NEEDS_SNOOP: assert property (@(posedge clk) disable iff (!rst_n)
        snp_supply |-> snp_valid); // R10
    AST_CLASH_HOLDS_CPU: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_valid && snp_valid && !bus_req &&
         snp_addr[IDX_W-1:0] == cpu_addr[IDX_W-1:0]) |-> !cpu_ready); // R12
endmodule

bind wo_line_ctrl wo_line_chk #(.LINES(LINES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_valid  (cpu_valid),
    .cpu_addr   (cpu_addr),
    .cpu_ready  (cpu_ready),
    .cpu_rdata  (cpu_rdata),
    .bus_req    (bus_req),
    .bus_cmd    (bus_cmd),
    .bus_addr   (bus_addr),
    .bus_done   (bus_done),
    .bus_rdata  (bus_rdata),
    .snp_valid  (snp_valid),
    .snp_addr   (snp_addr),
    .snp_supply (snp_supply)
);

// File: tb/wo_line_ctrl_test.sv
module wo_line_ctrl_test;
    localparam int LINES  = 2048;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 64;
    localparam int IDX_W  = $clog2(LINES);
    localparam int TAG_W  = ADDR_W - IDX_W;
    localparam time CLK_PERIOD = 10ns;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cpu_valid = 1'b0;
    logic              cpu_write = 1'b0;
    logic [ADDR_W-1:0] cpu_addr = '0;
    logic [DATA_W-1:0] cpu_wdata = '0;
    logic              cpu_ready;
    logic [DATA_W-1:0] cpu_rdata;
    logic              bus_req;
    logic [1:0]        bus_cmd;
    logic [ADDR_W-1:0] bus_addr;
    logic [DATA_W-1:0] bus_wdata;
    logic              bus_done = 1'b0;
    logic [DATA_W-1:0] bus_rdata = '0;
    logic              snp_valid = 1'b0;
    logic [1:0]        snp_cmd = '0;
    logic [ADDR_W-1:0] snp_addr = '0;
    logic              snp_supply;
    logic [DATA_W-1:0] snp_rdata;

    always #(CLK_PERIOD / 2) clk = ~clk;

    wo_line_ctrl #(.LINES(LINES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) uut (
        .clk(clk), .rst_n(rst_n),
        .cpu_valid(cpu_valid), .cpu_write(cpu_write), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
        .bus_req(bus_req), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_done(bus_done), .bus_rdata(bus_rdata),
        .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
        .snp_supply(snp_supply), .snp_rdata(snp_rdata)
    );

    // model: 0 absent, 1 clean-shared, 2 exclusive-unmodified, 3 exclusive-modified
    logic [1:0]        m_st   [LINES];
    logic [TAG_W-1:0]  m_tag  [LINES];
    logic [DATA_W-1:0] m_data [LINES];
    logic [DATA_W-1:0] mem [int];

    logic [1:0]        ex_cmd  [3];
    logic [ADDR_W-1:0] ex_addr [3];
    logic [DATA_W-1:0] ex_data [3];
    int ex_n;
    int total = 0;
    int bad = 0;

    function automatic logic [DATA_W-1:0] mem_rd(input logic [ADDR_W-1:0] a);
        if (mem.exists(int'(a))) return mem[int'(a)];
        return {16'hC0DE, a, ~a, 16'h5A5A};
    endfunction

    task automatic check(input logic ok, input string req, input string what,
                         input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic push(input logic [1:0] c, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        ex_cmd[ex_n] = c; ex_addr[ex_n] = a; ex_data[ex_n] = d; ex_n++;
    endtask

    task automatic do_cpu(input logic w, input logic [ADDR_W-1:0] a,
                          input logic [DATA_W-1:0] d, input string req);
        logic [IDX_W-1:0] i = a[IDX_W-1:0];
        logic [TAG_W-1:0] t = a[ADDR_W-1:IDX_W];
        logic hit = (m_st[i] != 2'd0) && (m_tag[i] == t);
        logic [DATA_W-1:0] exp_rd;
        logic got = 1'b0;
        logic seen = 1'b0;
        int n = 0;
        int lat = 0;
        ex_n = 0;
        exp_rd = hit ? m_data[i] : mem_rd(a);
        if (!(hit && (!w || m_st[i] >= 2'd2))) begin
            if (!hit && m_st[i] == 2'd3) push(2'd2, {m_tag[i], i}, m_data[i]);
            if (!hit) push(w ? 2'd1 : 2'd0, a, '0);
            if (w) push(2'd2, a, d);
        end
        @(negedge clk);
        cpu_valid = 1'b1; cpu_write = w; cpu_addr = a; cpu_wdata = d;
        for (int c = 0; c < 60 && !got; c++) begin
            #1;
            if (bus_req && !seen) begin
                seen = 1'b1;
                lat = int'($urandom % 3);
                if (n >= ex_n) begin
                    check(1'b0, req, "unexpected bus request cmd", 64'(bus_cmd), 64'(3));
                end else begin
                    check(bus_cmd == ex_cmd[n], req, "bus cmd", 64'(bus_cmd), 64'(ex_cmd[n]));
                    check(bus_addr == ex_addr[n], req, "bus addr", 64'(bus_addr), 64'(ex_addr[n]));
                    if (ex_cmd[n] == 2'd2)
                        check(bus_wdata == ex_data[n], req, "bus write data", bus_wdata, ex_data[n]);
                end
            end
            if (bus_req && seen) begin
                if (lat == 0) begin
                    bus_done = 1'b1;
                    bus_rdata = mem_rd(bus_addr);
                    if (bus_cmd == 2'd2) mem[int'(bus_addr)] = bus_wdata;
                    n++;
                    seen = 1'b0;
                    #1;
                end else begin
                    lat--;
                end
            end
            if (cpu_ready) begin
                got = 1'b1;
                if (!w) check(cpu_rdata == exp_rd, req, "load data", cpu_rdata, exp_rd);
            end
            @(posedge clk);
            @(negedge clk);
            bus_done = 1'b0;
            if (got) cpu_valid = 1'b0;
        end
        check(got, req, "request completed", 64'(got), 64'(1));
        check(n == ex_n, req, "bus cycle count", 64'(n), 64'(ex_n));
        cpu_valid = 1'b0;
        if (w) begin
            m_st[i] = (hit && m_st[i] >= 2'd2) ? 2'd3 : 2'd2;
            m_data[i] = d;
        end else if (!hit) begin
            m_st[i] = 2'd1;
            m_data[i] = exp_rd;
        end
        m_tag[i] = t;
    endtask

    task automatic do_snoop(input logic [1:0] c, input logic [ADDR_W-1:0] a, input string req);
        logic [IDX_W-1:0] i = a[IDX_W-1:0];
        logic hit = (m_st[i] != 2'd0) && (m_tag[i] == a[ADDR_W-1:IDX_W]);
        @(negedge clk);
        snp_valid = 1'b1; snp_cmd = c; snp_addr = a;
        #1;
        check(snp_supply == hit, req, "snoop supply", 64'(snp_supply), 64'(hit));
        if (hit) check(snp_rdata == m_data[i], req, "snoop data", snp_rdata, m_data[i]);
        @(posedge clk);
        @(negedge clk);
        snp_valid = 1'b0;
        if (hit) begin
            mem[int'(a)] = m_data[i];
            m_st[i] = c[0] ? 2'd0 : 2'd1;
        end
    endtask

    function automatic logic [ADDR_W-1:0] mk(input int t, input int i);
        return {TAG_W'(t), IDX_W'(i)};
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < LINES; i++) m_st[i] = 2'd0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(!cpu_ready && !bus_req && !snp_supply, "R1", "outputs idle after reset",
              64'({cpu_ready, bus_req, snp_supply}), 64'(0));
        do_snoop(2'd0, mk(3, 9), "R1");
        do_cpu(1'b0, mk(1, 5), '0, "R1");

        do_cpu(1'b0, mk(2, 7), '0, "R2");
        do_cpu(1'b0, mk(2, 7), '0, "R2");
        do_snoop(2'd0, mk(2, 7), "R7");
        do_cpu(1'b0, mk(2, 7), '0, "R7");
        do_cpu(1'b1, mk(2, 7), 64'h1111_2222_3333_4444, "R4");
        do_cpu(1'b1, mk(2, 7), 64'h5555_6666_7777_8888, "R5");
        do_snoop(2'd2, mk(2, 7), "R8");
        do_cpu(1'b1, mk(2, 7), 64'h9999_AAAA_BBBB_CCCC, "R8");
        do_cpu(1'b1, mk(4, 7), 64'hDEAD_BEEF_0000_0001, "R3");
        do_cpu(1'b1, mk(4, 7), 64'hDEAD_BEEF_0000_0002, "R5");
        do_cpu(1'b0, mk(6, 7), '0, "R6");
        do_cpu(1'b1, mk(6, 7), 64'h0123_4567_89AB_CDEF, "R4");
        do_cpu(1'b0, mk(1, 7), '0, "R6");
        do_snoop(2'd1, mk(1, 7), "R9");
        do_cpu(1'b0, mk(1, 7), '0, "R9");
        do_snoop(2'd0, mk(5, 7), "R10");
        do_snoop(2'd1, mk(5, 7), "R10");
        do_cpu(1'b0, mk(1, 7), '0, "R10");
        do_cpu(1'b1, mk(31, LINES - 1), 64'hFFFF_0000_FFFF_0000, "R3");
        do_cpu(1'b1, mk(31, LINES - 1), 64'h0000_FFFF_0000_FFFF, "R5");
        do_snoop(2'd3, mk(31, LINES - 1), "R9");
        do_cpu(1'b0, mk(31, LINES - 1), '0, "R9");

        // R12: snoop to the same index as a new request while idle
        do_cpu(1'b0, mk(0, 3), '0, "R12");
        @(negedge clk);
        cpu_valid = 1'b1; cpu_write = 1'b0; cpu_addr = mk(0, 3);
        snp_valid = 1'b1; snp_cmd = 2'd1; snp_addr = mk(0, 3);
        #1;
        check(!cpu_ready, "R12", "processor held during clash", 64'(cpu_ready), 64'(0));
        check(snp_supply, "R12", "snoop served during clash", 64'(snp_supply), 64'(1));
        @(posedge clk);
        @(negedge clk);
        snp_valid = 1'b0;
        cpu_valid = 1'b0;
        mem[int'(mk(0, 3))] = m_data[3];
        m_st[3] = 2'd0;
        do_cpu(1'b0, mk(0, 3), '0, "R12");

        for (int k = 0; k < 400; k++) begin
            int sel = int'($urandom % 4);
            int ii = (sel == 3) ? LINES - 1 : sel;
            logic [ADDR_W-1:0] a = mk(int'($urandom % 3), ii);
            if ($urandom % 10 < 6)
                do_cpu(1'($urandom % 2), a, {$urandom, $urandom}, "R11");
            else
                do_snoop(2'($urandom % 4), a, "R10");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule